// File: doc/BRIEF.md
# Sticky Error Status and Reporting

This block is the error-reporting corner of a bus controller. Detector logic elsewhere hands it single-cycle event pulses: a system bus time-out, an address or request parity error, an uncorrectable ECC error, a system bus protocol violation, a hard-fail response, a protocol violation on either of two expander buses, and an interrupt request from either of two performance monitors. Software sees two 16-bit registers through a simple port. One is a command register of enables. The other is a status register of sticky flags.

Three active-high outputs report errors to the rest of the system: bus-init, address-error and bus-error. Each one is a one-cycle pulse, gated by the enables in the command register. A fourth output, the interrupt request, is a level. It stays high while either performance-monitor flag is set.

The status flags sit in a power-on reset domain of their own, so an ordinary reset leaves them intact. Software reads them after recovery and clears them by writing ones. The interrupt request is tracked by a two-state machine in the power-on domain:
- `IRQ_QUIET` moves to `IRQ_RAISED` when the next status value has either monitor flag set.
- `IRQ_RAISED` moves back to `IRQ_QUIET` when the next status value has both flags clear.
- Power-on reset forces `IRQ_QUIET`.

Top module: `errrep_top`

## Requirements
- R1: Power-on reset (`por_n` low) clears the status register to 0000h, the command register to 0, all three error pulses, and the interrupt request.
- R2: Ordinary reset (`rst_n` low) clears the command register and the error pulses, but leaves every status bit and the interrupt request unchanged.
- R3: On the clock edge that samples an event, status bits set as follows, whatever the command register holds: a hard-fail response sets bit 12; an expander bus 1 violation sets bit 11; an expander bus 0 violation sets bit 10; a monitor 1 request sets bit 9; a monitor 0 request sets bit 8.
- R4: Writing to the status register clears each bit written as 1 and leaves each bit written as 0. If an event and a clear hit the same bit on the same edge, the bit stays set.
- R5: Status bits 15:13 and 7:0 always read 0. Events and writes cannot change them.
- R6: When command bit 0 is 1, a hard-fail response, a violation on either expander bus, or a system bus protocol violation raises `bus_init_o`. When command bit 0 is 0, none of them does.
- R7: A system bus time-out raises `bus_init_o` only when command bits 3 and 0 are both 1.
- R8: An address or request parity error raises `addr_err_o` only when command bit 2 is 1.
- R9: An uncorrectable ECC error raises `bus_err_o` only when command bit 1 is 1.
- R10: Each error output goes high in the cycle after the clock edge that samples the qualifying event. It stays high for exactly one cycle when the event lasted one cycle. The enables used are the command bits held before that edge.
- R11: `irq_o` is 1 exactly while status bit 8 or bit 9 is 1. It falls in the same cycle that the second of those bits is cleared.
- R12: `reg_sel` = 0 addresses the command register and `reg_sel` = 1 addresses the status register. Reads return data combinationally. The command register holds bits 3:0 only, and bits 15:4 read 0. Writes take effect on the clock edge while `reg_wr` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ev_timeout | input | 1 | System bus time-out pulse |
| ev_addr_par | input | 1 | Address or request parity error pulse |
| ev_ecc_uncorr | input | 1 | Uncorrectable ECC error pulse |
| ev_sys_proto | input | 1 | System bus protocol violation pulse |
| ev_hard_fail | input | 1 | Hard-fail response pulse |
| ev_xb_proto | input | 2 | Expander bus protocol violation pulses, index = bus |
| ev_pmon_irq | input | 2 | Performance monitor interrupt requests, index = monitor |
| bus_init_o | output | 1 | Bus-init pulse |
| addr_err_o | output | 1 | Address-error pulse |
| bus_err_o | output | 1 | Bus-error pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
Faults show up at the ports in different ways. A wrong status flop shows at `reg_rdata` on the very next read of the status register. A command bit stuck at the wrong value shows one cycle after the next qualifying event, as a missing or extra pulse. If the interrupt state machine drifts from the status bits, `irq_o` disagrees with the status read in the same cycle. A status register wrongly placed in the ordinary reset domain shows as lost flags on the first read after an ordinary reset.

// File: rtl/errrep_pkg.sv
package errrep_pkg;
    localparam int REG_W       = 16;
    localparam int CMD_W       = 4;
    // command enable positions (software-visible)
    localparam int C_INIT_EN   = 0;
    localparam int C_BERR_EN   = 1;
    localparam int C_AERR_EN   = 2;
    localparam int C_TOUT_EN   = 3;
    // status flag positions (software-visible)
    localparam int N_XB        = 2;
    localparam int N_PM        = 2;
    localparam int S_PM_LSB    = 8;
    localparam int S_XB_LSB    = S_PM_LSB + N_PM;
    localparam int S_HARD      = S_XB_LSB + N_XB;
    localparam int S_LIVE_W    = S_HARD - S_PM_LSB + 1;
    localparam logic [REG_W-1:0] S_IMPL =
        REG_W'(((1 << S_LIVE_W) - 1) << S_PM_LSB);

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;
endpackage

// File: rtl/errrep_cmd_reg.sv
module errrep_cmd_reg
    import errrep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_all_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q
);
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n)
            cmd_q <= '0;
        else if (wr_en)
            cmd_q <= wdata;
    end
endmodule

// File: rtl/errrep_status_reg.sv
module errrep_status_reg
    import errrep_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] st_q,
    output logic [REG_W-1:0] st_nxt
);
    logic [REG_W-1:0] clr_mask;

    always_comb begin
        clr_mask = {REG_W{clr_en}} & clr_data;
        // a new event outranks a clear on the same bit
        st_nxt   = S_IMPL & (set_i | (st_q & ~clr_mask));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            st_q <= '0;
        else
            st_q <= st_nxt;
    end
endmodule

// File: rtl/errrep_sig_gen.sv
module errrep_sig_gen
    import errrep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_all_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic             ev_timeout,
    input  logic             ev_addr_par,
    input  logic             ev_ecc_uncorr,
    input  logic             ev_sys_proto,
    input  logic             ev_hard_fail,
    input  logic [N_XB-1:0]  ev_xb_proto,
    output logic             bus_init_q,
    output logic             addr_err_q,
    output logic             bus_err_q
);
    logic proto_any;
    logic tout_qual;
    logic init_d;
    logic aerr_d;
    logic berr_d;

    always_comb begin
        proto_any = ev_hard_fail | (|ev_xb_proto) | ev_sys_proto;
        tout_qual = cmd[C_TOUT_EN] & ev_timeout;
        init_d    = cmd[C_INIT_EN] & (proto_any | tout_qual);
        aerr_d    = cmd[C_AERR_EN] & ev_addr_par;
        berr_d    = cmd[C_BERR_EN] & ev_ecc_uncorr;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            bus_init_q <= 1'b0;
            addr_err_q <= 1'b0;
            bus_err_q  <= 1'b0;
        end else begin
            bus_init_q <= init_d;
            addr_err_q <= aerr_d;
            bus_err_q  <= berr_d;
        end
    end
endmodule

// File: rtl/errrep_irq_fsm.sv
module errrep_irq_fsm
    import errrep_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic pm_any_nxt,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pm_any_nxt)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pm_any_nxt) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/errrep_top.sv
module errrep_top
    import errrep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ev_timeout,
    input  logic             ev_addr_par,
    input  logic             ev_ecc_uncorr,
    input  logic             ev_sys_proto,
    input  logic             ev_hard_fail,
    input  logic [N_XB-1:0]  ev_xb_proto,
    input  logic [N_PM-1:0]  ev_pmon_irq,
    output logic             bus_init_o,
    output logic             addr_err_o,
    output logic             bus_err_o,
    output logic             irq_o
);
    logic             rst_all_n;
    logic [CMD_W-1:0] cmd_q;
    logic [REG_W-1:0] st_q;
    logic [REG_W-1:0] st_nxt;
    logic [REG_W-1:0] st_set;
    logic             pm_any_nxt;

    assign rst_all_n = rst_n & por_n;

    always_comb begin
        st_set                       = '0;
        st_set[S_HARD]               = ev_hard_fail;
        st_set[S_XB_LSB +: N_XB]     = ev_xb_proto;
        st_set[S_PM_LSB +: N_PM]     = ev_pmon_irq;
    end

    errrep_cmd_reg u_cmd (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .wr_en     (reg_wr & ~reg_sel),
        .wdata     (reg_wdata[CMD_W-1:0]),
        .cmd_q     (cmd_q)
    );

    errrep_status_reg u_sts (
        .clk      (clk),
        .por_n    (por_n),
        .set_i    (st_set),
        .clr_en   (reg_wr & reg_sel),
        .clr_data (reg_wdata),
        .st_q     (st_q),
        .st_nxt   (st_nxt)
    );

    errrep_sig_gen u_sig (
        .clk           (clk),
        .rst_all_n     (rst_all_n),
        .cmd           (cmd_q),
        .ev_timeout    (ev_timeout),
        .ev_addr_par   (ev_addr_par),
        .ev_ecc_uncorr (ev_ecc_uncorr),
        .ev_sys_proto  (ev_sys_proto),
        .ev_hard_fail  (ev_hard_fail),
        .ev_xb_proto   (ev_xb_proto),
        .bus_init_q    (bus_init_o),
        .addr_err_q    (addr_err_o),
        .bus_err_q     (bus_err_o)
    );

    assign pm_any_nxt = |st_nxt[S_PM_LSB +: N_PM];

    errrep_irq_fsm u_irq (
        .clk        (clk),
        .por_n      (por_n),
        .pm_any_nxt (pm_any_nxt),
        .irq_o      (irq_o)
    );

    always_comb begin
        if (reg_sel)
            reg_rdata = st_q;
        else
            reg_rdata = {{(REG_W-CMD_W){1'b0}}, cmd_q};
    end
endmodule

// File: rtl/errrep_chk.sv
module errrep_chk
    import errrep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             ev_timeout,
    input logic             ev_addr_par,
    input logic             ev_ecc_uncorr,
    input logic             ev_sys_proto,
    input logic             ev_hard_fail,
    input logic [N_XB-1:0]  ev_xb_proto,
    input logic [CMD_W-1:0] cmd,
    input logic [REG_W-1:0] status,
    input logic             bus_init_o,
    input logic             addr_err_o,
    input logic             bus_err_o,
    input logic             irq_o
);
    a_r3_hard_sets: assert property (@(posedge clk) disable iff (!por_n)
        ev_hard_fail |=> status[S_HARD]);

    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!por_n)
        (status[S_HARD] && !(reg_wr && reg_sel && reg_wdata[S_HARD]))
        |=> status[S_HARD]);

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        (status & ~S_IMPL) == '0);

    a_r6_proto_init: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (ev_sys_proto && cmd[C_INIT_EN]) |=> bus_init_o);

    a_r7_tout_gated: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (ev_timeout && !cmd[C_TOUT_EN] && !ev_sys_proto && !ev_hard_fail
         && (ev_xb_proto == '0)) |=> !bus_init_o);

    a_r8_aerr_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        addr_err_o |-> $past(ev_addr_par && cmd[C_AERR_EN]));

    a_r9_berr_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        bus_err_o |-> $past(ev_ecc_uncorr && cmd[C_BERR_EN]));

    a_r11_irq_level: assert property (@(posedge clk) disable iff (!por_n)
        irq_o == (status[S_PM_LSB] || status[S_PM_LSB+1]));
endmodule

bind errrep_top errrep_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .ev_timeout    (ev_timeout),
    .ev_addr_par   (ev_addr_par),
    .ev_ecc_uncorr (ev_ecc_uncorr),
    .ev_sys_proto  (ev_sys_proto),
    .ev_hard_fail  (ev_hard_fail),
    .ev_xb_proto   (ev_xb_proto),
    .cmd           (cmd_q),
    .status        (st_q),
    .bus_init_o    (bus_init_o),
    .addr_err_o    (addr_err_o),
    .bus_err_o     (bus_err_o),
    .irq_o         (irq_o)
);

// File: tb/sim_errrep_top.sv
`timescale 1ns/1ps
module sim_errrep_top;
    logic        clk = 1'b0;
    logic        rst_n, por_n;
    logic        reg_wr, reg_sel;
    logic [15:0] reg_wdata, reg_rdata;
    logic        ev_timeout, ev_addr_par, ev_ecc_uncorr, ev_sys_proto, ev_hard_fail;
    logic [1:0]  ev_xb_proto, ev_pmon_irq;
    logic        bus_init_o, addr_err_o, bus_err_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    errrep_top u0 (.*);

    // vector: [15:12] cmd, [11:3] events, [2] bus-init, [1] addr-err, [0] bus-err
    // event order b8..b0: pm1 pm0 xb1 xb0 hard sys ecc addr tout
    localparam int NV = 14;
    localparam logic [15:0] VECS [NV] = '{
        {4'b0000, 9'b000010000, 3'b000},
        {4'b0001, 9'b000010000, 3'b100},
        {4'b0001, 9'b000100000, 3'b100},
        {4'b0001, 9'b001000000, 3'b100},
        {4'b0001, 9'b000001000, 3'b100},
        {4'b0001, 9'b000000001, 3'b000},
        {4'b1001, 9'b000000001, 3'b100},
        {4'b1000, 9'b000000001, 3'b000},
        {4'b0100, 9'b000000010, 3'b010},
        {4'b0010, 9'b000000100, 3'b001},
        {4'b0110, 9'b000000110, 3'b011},
        {4'b1111, 9'b001111111, 3'b111},
        {4'b0000, 9'b001111111, 3'b000},
        {4'b1111, 9'b110000000, 3'b000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_ev(input logic [8:0] e);
        ev_timeout    = e[0];
        ev_addr_par   = e[1];
        ev_ecc_uncorr = e[2];
        ev_sys_proto  = e[3];
        ev_hard_fail  = e[4];
        ev_xb_proto   = e[6:5];
        ev_pmon_irq   = e[8:7];
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        rst_n = 1'b0; por_n = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        drive_ev('0);
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r); chk("R1 cmd after power-on", r, 16'h0000);
        rd(1'b1, r); chk("R1 status after power-on", r, 16'h0000);
        chk("R1 outputs after power-on",
            {12'h0, bus_init_o, addr_err_o, bus_err_o, irq_o}, 16'h0000);

        // R12 command register width and readback
        wr(1'b0, 16'hFFFF);
        rd(1'b0, r); chk("R12 cmd readback", r, 16'h000F);

        // vector table: R3 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [8:0]  ev;
            logic [15:0] exp_st;
            ev = VECS[i][11:3];
            wr(1'b0, {12'h0, VECS[i][15:12]});
            wr(1'b1, 16'hFFFF);
            drive_ev(ev);
            @(negedge clk);
            drive_ev('0);
            chk("R6 R7 R8 R9 R10 pulse set",
                {13'h0, bus_init_o, addr_err_o, bus_err_o}, {13'h0, VECS[i][2:0]});
            exp_st = '0;
            exp_st[12] = ev[4];
            exp_st[11] = ev[6];
            exp_st[10] = ev[5];
            exp_st[9]  = ev[8];
            exp_st[8]  = ev[7];
            rd(1'b1, r); chk("R3 status flags after event", r, exp_st);
            chk("R11 irq level", {15'h0, irq_o}, {15'h0, ev[7] | ev[8]});
            @(negedge clk);
            chk("R10 pulse lasts one cycle",
                {13'h0, bus_init_o, addr_err_o, bus_err_o}, 16'h0000);
        end

        // R5 reserved bits stay zero; R4 partial clears
        wr(1'b1, 16'hFFFF);
        drive_ev(9'b111111111);
        @(negedge clk);
        drive_ev('0);
        rd(1'b1, r); chk("R5 reserved bits read zero", r, 16'h1F00);
        wr(1'b1, 16'h1000);
        rd(1'b1, r); chk("R4 write-one clears bit 12 only", r, 16'h0F00);
        wr(1'b1, 16'h0000);
        rd(1'b1, r); chk("R4 write-zero leaves bits", r, 16'h0F00);
        wr(1'b1, 16'hE0FF);
        rd(1'b1, r); chk("R5 write to reserved bits ignored", r, 16'h0F00);

        // R4 event beats clear on same edge
        ev_hard_fail = 1'b1;
        wr(1'b1, 16'h1C00);
        ev_hard_fail = 1'b0;
        rd(1'b1, r); chk("R4 event wins over clear", r, 16'h1300);

        // R11 irq held until both monitor flags are cleared
        wr(1'b1, 16'hFFFF);
        chk("R11 irq low when both clear", {15'h0, irq_o}, 16'h0000);
        ev_pmon_irq = 2'b01;
        @(negedge clk);
        ev_pmon_irq = 2'b10;
        @(negedge clk);
        ev_pmon_irq = 2'b00;
        wr(1'b1, 16'h0100);
        chk("R11 irq held by bit 9", {15'h0, irq_o}, 16'h0001);
        wr(1'b1, 16'h0200);
        chk("R11 irq drops after last clear", {15'h0, irq_o}, 16'h0000);

        // R2 ordinary reset keeps status
        drive_ev(9'b111110000);
        @(negedge clk);
        drive_ev('0);
        wr(1'b0, 16'h000F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, r); chk("R2 cmd cleared by ordinary reset", r, 16'h0000);
        rd(1'b1, r); chk("R2 status kept over ordinary reset", r, 16'h1F00);
        chk("R2 irq kept over ordinary reset", {15'h0, irq_o}, 16'h0001);
        ev_sys_proto = 1'b1;
        @(negedge clk);
        ev_sys_proto = 1'b0;
        chk("R6 no bus-init with enable clear", {15'h0, bus_init_o}, 16'h0000);

        // R1 power-on reset clears status
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd(1'b1, r); chk("R1 status cleared by power-on", r, 16'h0000);
        chk("R1 irq cleared by power-on", {15'h0, irq_o}, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule